// File: doc/BRIEF.md
# Display frame sync interrupt controller

This block produces horizontal and vertical sync for a raster display and tells the host when each frame begins and when it must stop touching the frame set-up registers. The timing generator counts pixels along a line and lines within a frame. For each axis, the active, front-porch, sync-pulse and back-porch lengths are programmable. The generator runs only while the mode register holds a legal nonzero value.

The host reaches a flat register file through a simple write port and a read port with one cycle of latency. Three sticky status bits record frame start, an early warning a programmed number of lines ahead of vertical blanking, and a writeback sync. Writing 1 to a status bit clears it. The interrupt line is the OR of the status bits that the mask register enables.

A load window runs from the first front-porch line to the end of the vertical sync pulse. The block drives this window on an output pin. While the window is open, writes to the plane-descriptor, palette, gamma and cursor pointers are dropped. A plane is reported enabled whenever its descriptor pointer is nonzero.

Top module: `dsync_top`

## Requirements
- R1: Mode register (address 0) resets to 0. While it is 0, hsync, vsync and fetch_win stay low. Once a value from 1 to 4 is written, timing runs with a frame period of (sum of the four vertical lengths) times (sum of the four horizontal lengths) cycles.
- R2: Status bit 0 (frame start; status at address 2) becomes set on the same clock edge at which vsync first goes high.
- R3: With threshold T (address 3) below the vertical active length VA, status bit 1 is set at the start of line VA-T. The set therefore happens (T + vertical front porch) lines before vsync rises.
- R4: A threshold of VA or more is clamped, so status bit 1 is set at the start of line 0, the first active line.
- R5: While fetch_win is high, writes to descriptor pointers (addresses 4, 5, 6), palette (7), gamma (8) and cursor (9) are ignored, and those registers keep their previous values. At other times the writes take effect.
- R6: fetch_win is high from the first vertical front-porch line through the last vsync line. It falls on the same edge as vsync.
- R7: plane_en[i] is 1 exactly while descriptor pointer i holds a nonzero value.
- R8: Mask register (address 1) resets to 0. irq is 1 only while some status bit is set and its mask bit is 1. A set status bit with a clear mask bit leaves irq at 0.
- R9: Writing 1 to a status bit clears it. If the bit's set event falls on the same edge as the clear, the set wins.
- R10: Status bit 2 (writeback sync) is set at vsync rise only while the mode is 2 or 3. In other modes it stays clear.
- R11: A mode write with a value above 4 is ignored, and the previous mode is kept.
- R12: hsync goes high for the programmed horizontal sync length (addresses 10 to 13: active, front porch, sync, back porch). It repeats once per line of horizontal-total cycles. Vertical lengths are at addresses 14 to 17 in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data valid |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| fetch_win | output | 1 | End-of-frame load window |
| plane_en | output | 3 | Per-plane enable flags |
| irq | output | 1 | Masked interrupt request |

## Verification
Two functions can land on the same edge: a host write-1-to-clear of the frame-start bit and the hardware set of that bit at vsync rise. The bench provokes this by first catching the rise of fetch_win. It then counts the known front-porch length in cycles and places the clear write on the exact edge where vsync rises. A later read of the status register must still show the bit set, and a second clear issued away from vsync must leave it clear.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int AW     = 5;
  localparam int DW     = 32;
  localparam int CW     = 12;
  localparam int TW     = CW + 2;
  localparam int NPLANE = 3;
  localparam int NSTAT  = 3;
  localparam int MODEW  = 3;
  localparam int MAXMODE = 4;

  localparam logic [AW-1:0] A_MODE  = 5'd0;
  localparam logic [AW-1:0] A_MASK  = 5'd1;
  localparam logic [AW-1:0] A_STAT  = 5'd2;
  localparam logic [AW-1:0] A_THR   = 5'd3;
  localparam logic [AW-1:0] A_DESC0 = 5'd4;
  localparam logic [AW-1:0] A_PAL   = 5'd7;
  localparam logic [AW-1:0] A_GAM   = 5'd8;
  localparam logic [AW-1:0] A_CUR   = 5'd9;
  localparam logic [AW-1:0] A_HACT  = 5'd10;
  localparam logic [AW-1:0] A_HFP   = 5'd11;
  localparam logic [AW-1:0] A_HSY   = 5'd12;
  localparam logic [AW-1:0] A_HBP   = 5'd13;
  localparam logic [AW-1:0] A_VACT  = 5'd14;
  localparam logic [AW-1:0] A_VFP   = 5'd15;
  localparam logic [AW-1:0] A_VSY   = 5'd16;
  localparam logic [AW-1:0] A_VBP   = 5'd17;

  typedef struct packed {
    logic [CW-1:0] act;
    logic [CW-1:0] fp;
    logic [CW-1:0] sy;
    logic [CW-1:0] bp;
  } span_t;
endpackage

// File: rtl/dsync_timing.sv
module dsync_timing
  import dsync_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  span_t         h_i,
  input  span_t         v_i,
  input  logic [CW-1:0] thr_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          fetch_o,
  output logic          fs_p_o,
  output logic          lbv_p_o
);
  logic [TW-1:0] hc, vc, hn, vn;
  logic [TW-1:0] ha, hfp, hsy, hbp, va, vfp, vsy, vbp;
  logic [TW-1:0] htot, vtot, tgt;
  logic          hs_n, vs_n, fw_n;

  always_comb begin
    ha  = TW'(h_i.act);  hfp = TW'(h_i.fp);
    hsy = TW'(h_i.sy);   hbp = TW'(h_i.bp);
    va  = TW'(v_i.act);  vfp = TW'(v_i.fp);
    vsy = TW'(v_i.sy);   vbp = TW'(v_i.bp);
    htot = ha + hfp + hsy + hbp;
    vtot = va + vfp + vsy + vbp;
    tgt  = (TW'(thr_i) >= va) ? '0 : va - TW'(thr_i);
  end

  // next-position logic: counters are held at the origin while off
  always_comb begin
    if (!en_i) begin
      hn = '0;
      vn = '0;
    end else if (hc >= htot - TW'(1)) begin
      hn = '0;
      vn = (vc >= vtot - TW'(1)) ? '0 : vc + TW'(1);
    end else begin
      hn = hc + TW'(1);
      vn = vc;
    end
    hs_n = en_i && (hn >= ha + hfp) && (hn < ha + hfp + hsy);
    vs_n = en_i && (vn >= va + vfp) && (vn < va + vfp + vsy);
    fw_n = en_i && (vn >= va) && (vn < va + vfp + vsy);
  end

  assign fs_p_o  = vs_n && !vsync_o;
  assign lbv_p_o = en_i && (hn == '0) && (vn == tgt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc      <= '0;
      vc      <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
      fetch_o <= 1'b0;
    end else begin
      hc      <= hn;
      vc      <= vn;
      hsync_o <= hs_n;
      vsync_o <= vs_n;
      fetch_o <= fw_n;
    end
  end

  p_vs_in_win_r6: assert property (@(posedge clk) disable iff (rst)
    vsync_o |-> fetch_o);

  p_fs_rise_r2: assert property (@(posedge clk) disable iff (rst)
    fs_p_o |=> (vsync_o && !$past(vsync_o)));
endmodule

// File: rtl/dsync_regs.sv
module dsync_regs
  import dsync_pkg::*;
#(
  parameter int H_ACT_D = 640, parameter int H_FP_D = 16,
  parameter int H_SY_D  = 96,  parameter int H_BP_D = 48,
  parameter int V_ACT_D = 480, parameter int V_FP_D = 10,
  parameter int V_SY_D  = 2,   parameter int V_BP_D = 33
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             lock_i,
  output logic [MODEW-1:0] mode_o,
  output logic [NSTAT-1:0] mask_o,
  output logic [CW-1:0]    thr_o,
  output span_t            h_o,
  output span_t            v_o,
  output logic [DW-1:0]    desc_o [NPLANE],
  output logic [DW-1:0]    pal_o,
  output logic [DW-1:0]    gam_o,
  output logic [DW-1:0]    cur_o,
  output logic [NSTAT-1:0] clr_o
);
  logic wr_ptr_ok;
  assign wr_ptr_ok = wr_en_i && !lock_i;
  assign clr_o = (wr_en_i && wr_addr_i == A_STAT) ? wr_data_i[NSTAT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= '0;
      mask_o <= '0;
      thr_o  <= '0;
      h_o    <= '{act: CW'(H_ACT_D), fp: CW'(H_FP_D), sy: CW'(H_SY_D), bp: CW'(H_BP_D)};
      v_o    <= '{act: CW'(V_ACT_D), fp: CW'(V_FP_D), sy: CW'(V_SY_D), bp: CW'(V_BP_D)};
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_MODE: if (wr_data_i <= DW'(MAXMODE)) mode_o <= wr_data_i[MODEW-1:0];
        A_MASK: mask_o   <= wr_data_i[NSTAT-1:0];
        A_THR:  thr_o    <= wr_data_i[CW-1:0];
        A_HACT: h_o.act  <= wr_data_i[CW-1:0];
        A_HFP:  h_o.fp   <= wr_data_i[CW-1:0];
        A_HSY:  h_o.sy   <= wr_data_i[CW-1:0];
        A_HBP:  h_o.bp   <= wr_data_i[CW-1:0];
        A_VACT: v_o.act  <= wr_data_i[CW-1:0];
        A_VFP:  v_o.fp   <= wr_data_i[CW-1:0];
        A_VSY:  v_o.sy   <= wr_data_i[CW-1:0];
        A_VBP:  v_o.bp   <= wr_data_i[CW-1:0];
        default: ;
      endcase
    end
  end

  // pointer registers: writes refused while the load window is open
  always_ff @(posedge clk) begin
    if (rst) begin
      pal_o <= '0;
      gam_o <= '0;
      cur_o <= '0;
    end else if (wr_ptr_ok) begin
      if (wr_addr_i == A_PAL) pal_o <= wr_data_i;
      if (wr_addr_i == A_GAM) gam_o <= wr_data_i;
      if (wr_addr_i == A_CUR) cur_o <= wr_data_i;
    end
  end

  for (genvar i = 0; i < NPLANE; i++) begin : g_desc
    always_ff @(posedge clk) begin
      if (rst)
        desc_o[i] <= '0;
      else if (wr_ptr_ok && wr_addr_i == A_DESC0 + AW'(i))
        desc_o[i] <= wr_data_i;
    end
  end

  p_ptr_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && lock_i && wr_addr_i == A_PAL) |=> $stable(pal_o));

  p_desc_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && lock_i && wr_addr_i == A_DESC0) |=> $stable(desc_o[0]));

  p_mode_legal_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == A_MODE && wr_data_i > DW'(MAXMODE)) |=> $stable(mode_o));
endmodule

// File: rtl/dsync_irq.sv
module dsync_irq
  import dsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSTAT-1:0] set_i,
  input  logic [NSTAT-1:0] clr_i,
  input  logic [NSTAT-1:0] mask_i,
  output logic [NSTAT-1:0] stat_o,
  output logic             irq_o
);
  logic [NSTAT-1:0] st_n;

  // a hardware set outranks a host clear in the same cycle
  assign st_n = (stat_o & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_o <= st_n;
      irq_o  <= |(st_n & mask_i);
    end
  end

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_i[0] |=> stat_o[0]);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|stat_o));
endmodule

// File: rtl/dsync_top.sv
module dsync_top
  import dsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              hsync,
  output logic              vsync,
  output logic              fetch_win,
  output logic [NPLANE-1:0] plane_en,
  output logic              irq
);
  logic [MODEW-1:0] mode;
  logic [NSTAT-1:0] mask, clr, stat, set;
  logic [CW-1:0]    thr;
  span_t            hsp, vsp;
  logic [DW-1:0]    desc [NPLANE];
  logic [DW-1:0]    pal, gam, cur;
  logic             fs_p, lbv_p, wb_p;
  logic [DW-1:0]    rd_mux;

  dsync_regs u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .lock_i(fetch_win), .mode_o(mode), .mask_o(mask), .thr_o(thr), .h_o(hsp), .v_o(vsp),
    .desc_o(desc), .pal_o(pal), .gam_o(gam), .cur_o(cur), .clr_o(clr)
  );

  dsync_timing u_tim (
    .clk(clk), .rst(rst), .en_i(mode != '0), .h_i(hsp), .v_i(vsp), .thr_i(thr),
    .hsync_o(hsync), .vsync_o(vsync), .fetch_o(fetch_win), .fs_p_o(fs_p), .lbv_p_o(lbv_p)
  );

  assign wb_p = fs_p && (mode == MODEW'(2) || mode == MODEW'(3));
  assign set  = {wb_p, lbv_p, fs_p};

  dsync_irq u_irq (
    .clk(clk), .rst(rst), .set_i(set), .clr_i(clr), .mask_i(mask),
    .stat_o(stat), .irq_o(irq)
  );

  for (genvar i = 0; i < NPLANE; i++) begin : g_pen
    assign plane_en[i] = (desc[i] != '0);
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_MODE: rd_mux = DW'(mode);
      A_MASK: rd_mux = DW'(mask);
      A_STAT: rd_mux = DW'(stat);
      A_THR:  rd_mux = DW'(thr);
      A_PAL:  rd_mux = pal;
      A_GAM:  rd_mux = gam;
      A_CUR:  rd_mux = cur;
      A_HACT: rd_mux = DW'(hsp.act);
      A_HFP:  rd_mux = DW'(hsp.fp);
      A_HSY:  rd_mux = DW'(hsp.sy);
      A_HBP:  rd_mux = DW'(hsp.bp);
      A_VACT: rd_mux = DW'(vsp.act);
      A_VFP:  rd_mux = DW'(vsp.fp);
      A_VSY:  rd_mux = DW'(vsp.sy);
      A_VBP:  rd_mux = DW'(vsp.bp);
      default: ;
    endcase
    for (int i = 0; i < NPLANE; i++)
      if (rd_addr == A_DESC0 + AW'(i)) rd_mux = desc[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  p_fs_with_vsync_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> stat[0]);

  p_wb_mode_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[2]) |-> ($past(mode) == MODEW'(2) || $past(mode) == MODEW'(3)));

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(mode) == '0 && mode == '0) |-> (!vsync && !hsync && !fetch_win));
endmodule

// File: tb/tb_dsync_top.sv
module tb_dsync_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid, hsync, vsync, fetch_win, irq;
  logic [2:0]  plane_en;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] q_exp[$], q_msk[$];
  string       q_tag[$];

  localparam int HT = 14, VFPL = 2;

  dsync_top dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .hsync(hsync), .vsync(vsync), .fetch_win(fetch_win), .plane_en(plane_en), .irq(irq));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 150000) begin
    errors = errors + 1;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per returned read
  always @(negedge clk) if (!rst && rd_valid) begin
    checks++;
    if (q_exp.size() == 0) begin
      errors++;
      $display("FAIL unexpected read act=%0h exp=none", rd_data);
    end else begin
      logic [31:0] e, m; string t;
      e = q_exp.pop_front(); m = q_msk.pop_front(); t = q_tag.pop_front();
      if ((rd_data & m) != (e & m)) begin
        errors++;
        $display("FAIL %s act=%0h exp=%0h", t, rd_data & m, e & m);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input logic [31:0] m,
                    input string tag);
    q_exp.push_back(e); q_msk.push_back(m); q_tag.push_back(tag);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  function automatic logic pick(input int s);
    case (s)
      0: pick = vsync;
      1: pick = irq;
      2: pick = fetch_win;
      default: pick = hsync;
    endcase
  endfunction

  task automatic wait_rise(input int s, output int t);
    logic p;
    @(negedge clk); p = pick(s);
    forever begin
      @(negedge clk);
      if (pick(s) && !p) break;
      p = pick(s);
    end
    t = cyc;
  endtask

  task automatic high_len(input int s, output int n);
    n = 0;
    while (pick(s)) begin n++; @(negedge clk); end
  endtask

  task automatic lbv_dist(input int thr, input int exp, input string tag);
    int a, b;
    wr(5'd3, thr);
    wr(5'd2, 32'h7);
    wait_rise(0, a);
    wr(5'd2, 32'h7);
    wait_rise(1, a);
    wait_rise(0, b);
    check(tag, b - a, exp);
  endtask

  initial begin
    int t0, t1, n;
    logic pv, pi;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    check("R8 irq after reset", irq, 0);
    check("R1 vsync after reset", vsync, 0);
    check("R7 plane_en after reset", plane_en, 0);
    rd(5'd1, 0, 32'hffff_ffff, "R8 mask reset");
    rd(5'd0, 0, 32'hffff_ffff, "R1 mode reset");

    wr(5'd10, 8); wr(5'd11, 2); wr(5'd12, 2); wr(5'd13, 2);
    wr(5'd14, 6); wr(5'd15, 2); wr(5'd16, 2); wr(5'd17, 2);

    // illegal mode while off, then unit must stay quiet
    wr(5'd0, 7);
    rd(5'd0, 0, 32'hffff_ffff, "R11 illegal mode ignored while off");
    n = 0;
    repeat (300) begin @(negedge clk); if (vsync || hsync || fetch_win) n++; end
    check("R1 outputs quiet while off", n, 0);

    wr(5'd0, 1);
    wait_rise(0, t0); wait_rise(0, t1);
    check("R1 frame period", t1 - t0, 12 * HT);

    wait_rise(3, t0); high_len(3, n);
    check("R12 hsync width", n, 2);
    wait_rise(3, t0); wait_rise(3, t1);
    check("R12 hsync period", t1 - t0, HT);

    // load window shape
    wait_rise(2, t0); high_len(2, n);
    check("R6 fetch window length", n, (2 + 2) * HT);
    check("R6 vsync low when window closes", vsync, 0);
    wait_rise(2, t0); wait_rise(0, t1);
    check("R6 window opens ahead of vsync", t1 - t0, VFPL * HT);

    // frame start on the vsync edge itself
    wr(5'd1, 1); wr(5'd2, 7);
    @(negedge clk); pv = vsync; pi = irq;
    forever begin
      @(negedge clk);
      if (vsync && !pv) break;
      pv = vsync; pi = irq;
    end
    check("R2 irq at vsync rise", irq, 1);
    check("R2 irq before vsync rise", pi, 0);

    // early warning distance and clamping
    wr(5'd1, 2);
    lbv_dist(2, (2 + VFPL) * HT, "R3 threshold 2");
    lbv_dist(0, VFPL * HT, "R3 threshold 0");
    lbv_dist(10, (6 + VFPL) * HT, "R4 threshold clamp 10");
    lbv_dist(6, (6 + VFPL) * HT, "R4 threshold equal to active");

    // masked source does not raise irq
    wr(5'd1, 0); wr(5'd2, 7);
    wait_rise(0, t0);
    @(negedge clk);
    check("R8 irq low with mask clear", irq, 0);
    rd(5'd2, 1, 1, "R8 status set though masked");

    // writeback bit by mode
    wr(5'd2, 7); wait_rise(0, t0);
    rd(5'd2, 0, 4, "R10 writeback clear in mode 1");
    wr(5'd0, 2); wr(5'd2, 7); wait_rise(0, t0);
    rd(5'd2, 4, 4, "R10 writeback set in mode 2");
    wr(5'd0, 5);
    rd(5'd0, 2, 32'hffff_ffff, "R11 mode 5 ignored");

    // clear colliding with frame-start set
    wait_rise(2, t0);
    repeat (VFPL * HT - 1) @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd2; wr_data = 1;
    @(negedge clk); wr_en = 1'b0;
    check("R9 vsync rose at collision edge", vsync, 1);
    rd(5'd2, 1, 1, "R9 set wins over clear");
    wr(5'd2, 1);
    rd(5'd2, 0, 1, "R9 write one clears");

    // plane enables, written outside the window
    wait_rise(0, t0); @(negedge vsync);
    wr(5'd5, 32'h100);
    @(negedge clk); check("R7 plane1 on", plane_en, 3'b010);
    wr(5'd4, 32'h4);
    @(negedge clk); check("R7 plane0 on", plane_en, 3'b011);
    wr(5'd5, 0);
    @(negedge clk); check("R7 plane1 off", plane_en, 3'b001);
    wr(5'd7, 32'h1111);

    // pointer lock inside the window
    wait_rise(2, t0);
    wr(5'd7, 32'h2222);
    wr(5'd6, 32'h9);
    wr(5'd8, 32'h77);
    check("R5 locked window still open", fetch_win, 1);
    check("R5 descriptor write refused", plane_en, 3'b001);
    rd(5'd7, 32'h1111, 32'hffff_ffff, "R5 palette kept");
    rd(5'd8, 0, 32'hffff_ffff, "R5 gamma kept");
    @(negedge fetch_win);
    wr(5'd7, 32'h3333);
    rd(5'd7, 32'h3333, 32'hffff_ffff, "R5 palette written outside window");

    repeat (4) @(negedge clk);
    check("scoreboard drained", q_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule